// File: doc/BRIEF.md
# Single-Word SPI Master with Select Timing and Slave-Ready Handshake

This block shifts one data word at a time out of a serial master port. It samples the returned word on the same transfer. The serial clock runs at a programmable fraction of the system clock. All four combinations of clock idle level and capture phase are supported. A word is handed in with a valid/ready handshake. The received word comes back on a one-cycle strobe together with its data.

Each transfer is framed in one of two ways, chosen per word by the `useEnable` input.

- **Select mode.** The master drives an active-low select line. Two delays are programmable:
  - a setup gap between the select falling and the first clock edge;
  - a hold gap between the last clock edge and the select rising.
  
  A hold flag lets the select stay low across back-to-back words when the next word is already waiting.
- **Enable mode.** The select line is left high. Each word is gated by an active-low ready line from the slave. That line passes through a two-flop synchronizer, and no clock edge is issued until the synchronized line shows the slave ready. A slave that keeps the line low is treated as ready for the next word at once.

Top module: `spi_word_master`

## Requirements
- R1: While reset is applied and directly after it, `csN` is 1, `sclk` is 0 (with `cpol` 0), `txReady` is 1 and `rxValid` is 0.
- R2: Words are shifted most significant bit first on `mosi`, and `rxData` holds the word captured from `miso`. With `cpha` 0, data is captured on the leading edge and changed on the trailing edge; with `cpha` 1, the reverse. The leading edge moves `sclk` away from `cpol`, so with `cpol` 0 it is a rising edge.
- R3: Consecutive `sclk` edges within a word are `clkDiv`+1 system clocks apart, and `sclk` rests at the level of `cpol` whenever no word is being shifted.
- R4: In select mode, the number of system clocks from `csN` falling to the first `sclk` edge is 2 + `c2tDelay` + H, plus a further H when `cpha` is 1, where H = `clkDiv`+1. The first edge is therefore never sooner than 2 cycles after `csN` falls.
- R5: In select mode, `csN` rises exactly 2 + `t2cDelay` system clocks after the last `sclk` edge of a word, unless R6 keeps it low.
- R6: With `csHold` at 1 and a next select-mode word already offered on `txValid`, `csN` stays low between the two words. With `csHold` at 0, `csN` returns high between them.
- R7: In enable mode, `csN` stays 1 and no `sclk` edge occurs while `slvEnN` is high. The word starts only after `slvEnN` is seen low through the two-stage synchronizer.
- R8: In enable mode, if `slvEnN` stays low after a word, a word offered next is shifted without any need for `slvEnN` to go high first.
- R9: A word is taken when `txValid` and `txReady` are both 1 on a clock edge, and `txReady` is 0 in the following cycle. `rxValid` pulses for exactly one cycle per word, with `rxData` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| useEnable | input | 1 | 0 frames words with `csN`, 1 gates words on `slvEnN` |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 captures on the leading edge, 1 captures on the trailing edge |
| clkDiv | input | DIV_W | Serial half period minus one, in system clocks |
| c2tDelay | input | DLY_W | Extra select-to-first-edge cycles |
| t2cDelay | input | DLY_W | Extra last-edge-to-release cycles |
| csHold | input | 1 | Keep select low across back-to-back words |
| txValid | input | 1 | A word is offered on `txData` |
| txData | input | DATA_W | Word to transmit |
| txReady | output | 1 | The master takes the offered word on this edge |
| rxValid | output | 1 | One-cycle strobe: received word on `rxData` |
| rxData | output | DATA_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low slave select |
| slvEnN | input | 1 | Active-low slave ready, asynchronous |

## Verification
The hardest situation to reach from the ports is the hand-over in the release cycle. There, a second word must already be waiting, so that the select either stays low (hold flag set) or the enable gate is reused without the slave letting go. The stimulus gets there by offering the next word as soon as the first is taken and holding `txValid` high until `txReady` returns in that single cycle. A bench slave model reacts to every serial edge at the falling system clock, so the setup, hold and edge spacings can be counted in whole cycles for each of the four clock modes and at the largest delay fields.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_RELEASE
  } spiState_t;

  // strobes from the controller to the datapath, one cycle each
  typedef struct packed {
    logic load;     // take txData into the shift register
    logic csSet;    // drive select low
    logic csClr;    // drive select high
    logic toggle;   // serial clock edge
    logic capture;  // sample miso
    logic shift;    // advance mosi
    logic done;     // present received word
    logic park;     // hold serial clock at its idle level
  } spiStrobes_t;

endpackage

// File: rtl/spi_wm_sync.sv
module spi_wm_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [NST-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= {NST{RESET_VAL}};
    else       stageQ <= {stageQ[NST-2:0], asyncIn};
  end

  assign syncOut = stageQ[NST-1];
endmodule

// File: rtl/spi_wm_ctrl.sv
module spi_wm_ctrl
  import spi_wm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             useEnable,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [DLY_W-1:0] c2tDelay,
  input  logic [DLY_W-1:0] t2cDelay,
  input  logic             csHold,
  input  logic             txValid,
  input  logic             enSyncN,
  output logic             txReady,
  output spiStrobes_t      stb,
  output logic             parkLevel,
  output logic             shiftActive,
  output logic             xferEnMode,
  output logic             busy
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int CNT_W  = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 2;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  spiState_t         state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [DIV_W-1:0]  halfCnt, halfNxt;
  logic [EDGE_W-1:0] edgeCnt, edgeNxt;
  logic              latchCfg;

  logic              cfgCpol, cfgCpha, cfgEn;
  logic [DIV_W-1:0]  cfgDiv;
  logic [DLY_W-1:0]  cfgT2c;

  logic edgeNow, leading;

  // load value for the setup counter: length minus one
  function automatic logic [CNT_W-1:0] setupLoad(input logic enM, input logic ph,
                                                 input logic [DIV_W-1:0] dv,
                                                 input logic [DLY_W-1:0] c2t);
    logic [CNT_W-1:0] base, extra;
    base  = enM ? CNT_W'(1) : CNT_W'(2) + CNT_W'(c2t);
    extra = ph ? CNT_W'(dv) + CNT_W'(1) : '0;
    return base + extra - CNT_W'(1);
  endfunction

  assign edgeNow = (halfCnt == cfgDiv);
  assign leading = ~edgeCnt[0];

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    halfNxt  = halfCnt;
    edgeNxt  = edgeCnt;
    latchCfg = 1'b0;
    txReady  = 1'b0;
    stb      = '0;
    stb.park = (state != ST_SHIFT);

    case (state)
      ST_IDLE: begin
        txReady = 1'b1;
        if (txValid) begin
          stb.load = 1'b1;
          latchCfg = 1'b1;
          if (useEnable) begin
            stateNxt = ST_WAIT_RDY;
          end else begin
            stb.csSet = 1'b1;
            stateNxt  = ST_SETUP;
            cntNxt    = setupLoad(1'b0, cpha, clkDiv, c2tDelay);
          end
        end
      end

      ST_WAIT_RDY: begin
        if (!enSyncN) begin
          stateNxt = ST_SETUP;
          cntNxt   = setupLoad(1'b1, cfgCpha, cfgDiv, '0);
        end
      end

      ST_SETUP: begin
        if (cnt == '0) begin
          stateNxt = ST_SHIFT;
          halfNxt  = '0;
          edgeNxt  = '0;
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end

      ST_SHIFT: begin
        if (edgeNow) begin
          stb.toggle  = 1'b1;
          stb.capture = cfgCpha ? ~leading : leading;
          stb.shift   = cfgCpha ? (leading && edgeCnt != '0)
                                : (~leading && edgeCnt != LAST_EDGE);
          halfNxt     = '0;
          if (edgeCnt == LAST_EDGE) begin
            stateNxt = ST_HOLD;
            cntNxt   = cfgEn ? '0 : CNT_W'(cfgT2c);
          end else begin
            edgeNxt = edgeCnt + EDGE_W'(1);
          end
        end else begin
          halfNxt = halfCnt + DIV_W'(1);
        end
      end

      ST_HOLD: begin
        if (cnt == '0) stateNxt = ST_RELEASE;
        else           cntNxt   = cnt - CNT_W'(1);
      end

      ST_RELEASE: begin
        stb.done = 1'b1;
        txReady  = useEnable ? cfgEn : (~cfgEn && csHold);
        if (txValid && txReady) begin
          stb.load = 1'b1;
          latchCfg = 1'b1;
          if (useEnable) begin
            stb.csClr = 1'b1;
            stateNxt  = ST_WAIT_RDY;
          end else begin
            stb.csSet = 1'b1;
            stateNxt  = ST_SETUP;
            cntNxt    = setupLoad(1'b0, cpha, clkDiv, c2tDelay);
          end
        end else begin
          stb.csClr = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end

      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      halfCnt <= halfNxt;
      edgeCnt <= edgeNxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgCpol <= 1'b0;
      cfgCpha <= 1'b0;
      cfgEn   <= 1'b0;
      cfgDiv  <= '0;
      cfgT2c  <= '0;
    end else if (latchCfg) begin
      cfgCpol <= cpol;
      cfgCpha <= cpha;
      cfgEn   <= useEnable;
      cfgDiv  <= clkDiv;
      cfgT2c  <= t2cDelay;
    end
  end

  assign parkLevel   = (state == ST_IDLE) ? cpol : cfgCpol;
  assign shiftActive = (state == ST_SHIFT);
  assign busy        = (state != ST_IDLE);
  assign xferEnMode  = cfgEn;
endmodule

// File: rtl/spi_wm_datapath.sv
module spi_wm_datapath
  import spi_wm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       stb,
  input  logic              parkLevel,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.load)       txShift <= txData;
      else if (stb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.capture)    rxShift <= {rxShift[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk <= 1'b0;
      csN  <= 1'b1;
    end else begin
      if (stb.toggle)    sclk <= ~sclk;
      else if (stb.park) sclk <= parkLevel;
      if (stb.csSet)      csN <= 1'b0;
      else if (stb.csClr) csN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= stb.done;
      if (stb.done) rxData <= rxShift;
    end
  end

  assign mosi = txShift[DATA_W-1];
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int DLY_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              useEnable,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [DLY_W-1:0]  c2tDelay,
  input  logic [DLY_W-1:0]  t2cDelay,
  input  logic              csHold,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  input  logic              slvEnN
);
  spiStrobes_t stb;
  logic enSyncN, parkLevel, shiftActive, xferEnMode, busy;

  spi_wm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(slvEnN), .syncOut(enSyncN)
  );

  spi_wm_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .useEnable(useEnable), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .c2tDelay(c2tDelay), .t2cDelay(t2cDelay), .csHold(csHold),
    .txValid(txValid), .enSyncN(enSyncN), .txReady(txReady), .stb(stb),
    .parkLevel(parkLevel), .shiftActive(shiftActive), .xferEnMode(xferEnMode),
    .busy(busy)
  );

  spi_wm_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .parkLevel(parkLevel), .txData(txData),
    .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN), .rxValid(rxValid),
    .rxData(rxData)
  );
endmodule

// File: rtl/spi_wm_checker.sv
module spi_wm_checker (
  input logic clk,
  input logic rstN,
  input logic useEnable,
  input logic csN,
  input logic sclk,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic shiftActive,
  input logic xferEnMode,
  input logic busy
);
  // R4: select is low for every shifted bit of a select-mode word
  assert_cs_low_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftActive && !xferEnMode) |-> !csN);

  // R4: at least two quiet cycles after select falls
  assert_setup_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> $stable(sclk) ##1 $stable(sclk));

  // R6: a word taken while select is low in select mode keeps it low
  assert_hold_keeps_cs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !csN && !useEnable) |=> !csN);

  // R7: enable-mode words never drive select
  assert_en_mode_no_cs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferEnMode) |-> csN);

  // R9: receive strobe lasts one cycle
  assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9: ready drops after a word is taken
  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
endmodule

bind spi_word_master spi_wm_checker chk_i (
  .clk(clk), .rstN(rstN), .useEnable(useEnable), .csN(csN), .sclk(sclk),
  .txValid(txValid), .txReady(txReady), .rxValid(rxValid),
  .shiftActive(shiftActive), .xferEnMode(xferEnMode), .busy(busy)
);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb_top;
  localparam int W = 8;
  localparam int EDGES = 2 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic useEnable = 1'b0, cpol = 1'b0, cpha = 1'b0, csHold = 1'b0;
  logic [7:0] clkDiv = '0;
  logic [4:0] c2tDelay = '0, t2cDelay = '0;
  logic txValid = 1'b0;
  logic [W-1:0] txData = '0;
  logic txReady, rxValid, sclk, mosi, csN;
  logic [W-1:0] rxData;
  logic miso = 1'b0;
  logic slvEnN = 1'b1;

  spi_word_master dut_i (
    .clk(clk), .rstN(rstN), .useEnable(useEnable), .cpol(cpol), .cpha(cpha),
    .clkDiv(clkDiv), .c2tDelay(c2tDelay), .t2cDelay(t2cDelay), .csHold(csHold),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxValid(rxValid),
    .rxData(rxData), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN),
    .slvEnN(slvEnN)
  );

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;

  // monitor / slave model state
  int cyc = 0, edgeTotal = 0, firstEdgeCyc = 0, lastEdgeCyc = 0;
  int csFallCyc = 0, csRiseCyc = 0, csRiseCount = 0, badSpacing = 0, badLead = 0;
  int halfExp = 1, rxCount = 0, wordsIssued = 0;
  bit monOn = 0;
  logic prevSclk = 1'b0, prevCsN = 1'b1;
  logic [W-1:0] slvRxCur = '0;
  logic [W-1:0] slvTxQ[32];
  logic [W-1:0] slvRxQ[32];
  logic [W-1:0] rxLog[32];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prevCsN && !csN) csFallCyc = cyc;
      if (!prevCsN && csN) begin csRiseCyc = cyc; csRiseCount++; end
      prevCsN = csN;
      if (rxValid) begin rxLog[rxCount % 32] = rxData; rxCount++; end
      if (monOn && sclk != prevSclk) begin
        int e;
        int wi;
        e  = edgeTotal % EDGES;
        wi = (edgeTotal / EDGES) % 32;
        if (e == 0) firstEdgeCyc = cyc;
        else if (cyc - lastEdgeCyc != halfExp) badSpacing++;
        if (e % 2 == 0 && sclk == cpol) badLead++;
        if ((e % 2 == 0) != cpha) slvRxCur = {slvRxCur[W-2:0], mosi};
        if (e == EDGES - 1) slvRxQ[wi] = slvRxCur;
        lastEdgeCyc = cyc;
        edgeTotal++;
      end
      prevSclk = sclk;
      begin
        int e2;
        int w2;
        int k;
        e2 = edgeTotal % EDGES;
        w2 = (edgeTotal / EDGES) % 32;
        k  = cpha ? ((e2 == 0) ? 0 : (e2 - 1) / 2) : e2 / 2;
        if (k > W - 1) k = W - 1;
        miso = slvTxQ[w2][W-1-k];
      end
    end
  end

  task automatic offer(input logic [W-1:0] d);
    txValid = 1'b1;
    txData  = d;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitRx(input int target);
    for (int i = 0; i < 3000 && rxCount < target; i++) @(negedge clk);
  endtask

  task automatic setMode(input logic en, input logic pol, input logic ph,
                         input int dv, input int c2t, input int t2c, input logic hold);
    @(negedge clk);
    monOn = 0;
    useEnable = en; cpol = pol; cpha = ph; csHold = hold;
    clkDiv = 8'(dv); c2tDelay = 5'(c2t); t2cDelay = 5'(t2c);
    halfExp = dv + 1;
    repeat (3) @(negedge clk);
    monOn = 1;
  endtask

  // one select-mode word: data, setup, hold, spacing, idle level
  task automatic testCsWord(input logic pol, input logic ph, input int dv,
                            input int c2t, input int t2c,
                            input logic [W-1:0] mo, input logic [W-1:0] so);
    int rx0, w0, setupExp;
    setMode(1'b0, pol, ph, dv, c2t, t2c, 1'b0);
    rx0 = rxCount; w0 = wordsIssued;
    slvTxQ[w0 % 32] = so; wordsIssued++;
    badSpacing = 0; badLead = 0;
    offer(mo);
    waitRx(rx0 + 1);
    repeat (3) @(negedge clk);
    setupExp = 2 + c2t + (dv + 1) + (ph ? dv + 1 : 0);
    chk(rxLog[rx0 % 32] == so, "R2 rxData", int'(rxLog[rx0 % 32]), int'(so));
    chk(slvRxQ[w0 % 32] == mo, "R2 mosi word", int'(slvRxQ[w0 % 32]), int'(mo));
    chk(badLead == 0, "R2 leading edge direction", badLead, 0);
    chk(badSpacing == 0, "R3 half period", badSpacing, 0);
    chk(sclk == pol, "R3 idle level", int'(sclk), int'(pol));
    chk(firstEdgeCyc - csFallCyc == setupExp, "R4 setup gap",
        firstEdgeCyc - csFallCyc, setupExp);
    chk(csRiseCyc - lastEdgeCyc == 2 + t2c, "R5 hold gap",
        csRiseCyc - lastEdgeCyc, 2 + t2c);
  endtask

  // two words offered back to back in select mode
  task automatic testPair(input logic hold, input logic [W-1:0] m1, input logic [W-1:0] m2,
                          input logic [W-1:0] s1, input logic [W-1:0] s2);
    int rx0, w0, r0;
    setMode(1'b0, 1'b0, 1'b1, 1, 1, 1, hold);
    rx0 = rxCount; w0 = wordsIssued; r0 = csRiseCount;
    slvTxQ[w0 % 32] = s1; slvTxQ[(w0 + 1) % 32] = s2; wordsIssued += 2;
    offer(m1);
    offer(m2);
    waitRx(rx0 + 2);
    repeat (3) @(negedge clk);
    chk(rxLog[rx0 % 32] == s1 && rxLog[(rx0 + 1) % 32] == s2, "R6 pair data",
        int'(rxLog[(rx0 + 1) % 32]), int'(s2));
    chk(slvRxQ[(w0 + 1) % 32] == m2, "R6 pair mosi", int'(slvRxQ[(w0 + 1) % 32]), int'(m2));
    chk(csRiseCount - r0 == (hold ? 1 : 2), hold ? "R6 select held" : "R6 select released",
        csRiseCount - r0, hold ? 1 : 2);
  endtask

  task automatic testEnable();
    int rx0, w0, r0, e0;
    setMode(1'b1, 1'b0, 1'b0, 1, 0, 0, 1'b0);
    slvEnN = 1'b1;
    rx0 = rxCount; w0 = wordsIssued; r0 = csRiseCount; e0 = edgeTotal;
    slvTxQ[w0 % 32] = 8'h5A; wordsIssued++;
    offer(8'hC3);
    repeat (40) @(negedge clk);
    chk(edgeTotal == e0, "R7 no edge before ready", edgeTotal - e0, 0);
    chk(csN == 1'b1, "R7 select stays high", int'(csN), 1);
    slvEnN = 1'b0;
    waitRx(rx0 + 1);
    chk(rxLog[rx0 % 32] == 8'h5A, "R7 data after ready", int'(rxLog[rx0 % 32]), 'h5A);
    chk(slvRxQ[w0 % 32] == 8'hC3, "R7 mosi after ready", int'(slvRxQ[w0 % 32]), 'hC3);
    // ready kept low: next two words run back to back
    rx0 = rxCount; w0 = wordsIssued;
    slvTxQ[w0 % 32] = 8'h12; slvTxQ[(w0 + 1) % 32] = 8'hED; wordsIssued += 2;
    offer(8'h96);
    offer(8'h69);
    waitRx(rx0 + 2);
    chk(rxCount - rx0 == 2, "R8 words completed", rxCount - rx0, 2);
    chk(rxLog[rx0 % 32] == 8'h12 && rxLog[(rx0 + 1) % 32] == 8'hED, "R8 data",
        int'(rxLog[(rx0 + 1) % 32]), 'hED);
    chk(slvRxQ[(w0 + 1) % 32] == 8'h69, "R8 mosi", int'(slvRxQ[(w0 + 1) % 32]), 'h69);
    chk(csRiseCount == r0 && csN, "R7 select never driven", csRiseCount - r0, 0);
    slvEnN = 1'b1;
  endtask

  task automatic testHandshake();
    int rx0, w0;
    setMode(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
    rx0 = rxCount; w0 = wordsIssued;
    slvTxQ[w0 % 32] = 8'h3C; wordsIssued++;
    txValid = 1'b1; txData = 8'hA5;
    @(negedge clk);
    txValid = 1'b0;
    chk(txReady == 1'b0, "R9 ready low after take", int'(txReady), 0);
    waitRx(rx0 + 1);
    @(negedge clk);
    chk(rxValid == 1'b0, "R9 strobe one cycle", int'(rxValid), 0);
    chk(rxCount - rx0 == 1, "R9 one strobe per word", rxCount - rx0, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin slvTxQ[i] = '0; slvRxQ[i] = '0; rxLog[i] = '0; end
    repeat (4) @(negedge clk);
    chk(csN == 1'b1, "R1 reset select", int'(csN), 1);
    chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
    chk(txReady == 1'b1, "R1 reset ready", int'(txReady), 1);
    chk(rxValid == 1'b0, "R1 reset strobe", int'(rxValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && rxValid == 1'b0, "R1 after reset", int'(csN), 1);

    testCsWord(1'b0, 1'b0, 0, 0, 0, 8'hA5, 8'h3C);
    testCsWord(1'b0, 1'b1, 1, 3, 2, 8'h00, 8'hFF);
    testCsWord(1'b1, 1'b0, 2, 0, 5, 8'h81, 8'h7E);
    testCsWord(1'b1, 1'b1, 3, 31, 31, 8'hFF, 8'h00);
    testPair(1'b1, 8'h5C, 8'hE1, 8'h42, 8'hB7);
    testPair(1'b0, 8'h0F, 8'hF0, 8'h99, 8'h66);
    testEnable();
    testHandshake();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule